// File: doc/BRIEF.md
# Calendar Time Registers with Commit Flags

This block holds the current time of day and the calendar date as two packed 32-bit registers. A one-cycle second strobe advances them. Seconds and minutes wrap at 60. Hours wrap at 24 and carry into the day. The day wraps at the end of the month, using a month length table and a leap flag that software supplies. December carries into the year, which is a 6-bit offset from 1970.

Software writes do not take effect at once. A write to the time or date register is parked in a holding register and its busy flag in the control word is raised. The value is committed into the counting logic on the second strobe of the slow clock enable that follows. At that point the busy flag drops. Software is expected to wait until every busy flag reads clear, then write time before date. Between second strobes the registers do not move, so reading twice gives a consistent snapshot.

Top module: `clock_calendar`

## Requirements
- R1: After reset the time word reads 0x00000000 and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap 0), and the control word reads 0.
- R2: Time word layout: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16; every other bit reads 0, so writing 0xFFFFFFFF and committing reads back 0x001F3F3F.
- R3: Date word layout: day in bits 4:0, month in bits 11:8, year offset in bits 21:16, leap flag in bit 22; every other bit reads 0, so writing 0xFFFFFFFF and committing reads back 0x007F0F1F.
- R4: Register offsets are word index 0 = control, 1 = time, 2 = date. A write to time sets control bit 8, and a write to date sets control bit 7; the flag is visible in the cycle after the write. The old value keeps reading back while the flag is set.
- R5: A pending write commits in the cycle in which the second slow-enable strobe after the write arrives. The busy flag clears and the new value reads back from the next cycle.
- R6: Writes to time or date while that register's busy flag is set are ignored, and writes to the control word change nothing.
- R7: Each second strobe advances seconds; 59 wraps to 0 and carries to minutes, minute 59 carries to hours, and hour 23 wraps to 0 and carries to the day.
- R8: The day wraps to 1 after 31 in months 1, 3, 5, 7, 8, 10 and 12, after 30 in months 4, 6, 9 and 11, and in month 2 after 29 if the leap flag is set, else after 28; the month then advances.
- R9: Month 12 wraps to 1 and carries into the year offset; offset 63 wraps to 0. The leap flag is kept as software wrote it.
- R10: Without a second strobe or commit, both words stay unchanged, so back-to-back reads match.
- R11: When a commit and a second strobe fall in the same cycle, the committed value is loaded without being advanced, and a time commit suppresses the day carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle strobe per slow-clock period |
| sec_tick | input | 1 | One-cycle strobe per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word index: 0 control, 1 time, 2 date |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from addr |

## Verification
A busy flag reads set one cycle after its write. The new value reads back one cycle after the edge that samples the second slow strobe. An advance reads back one cycle after the edge that samples the second strobe. Every stimulus is therefore driven on a falling edge and read on the next falling edge, after exactly one rising edge has passed. Each check is placed at the falling edge where its result is due. Commit checks also read between the first and second slow strobe, to show the value has not moved yet.

// File: rtl/clock_calendar.sv
module clock_calendar #(
  parameter int COMMIT_SLOW = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        sec_tick,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int CW = $clog2(COMMIT_SLOW) + 1;
  localparam logic [1:0] A_CTRL = 2'd0, A_TIME = 2'd1, A_DATE = 2'd2;

  logic [5:0] sec_q, min_q, yr_q;
  logic [4:0] hr_q, day_q;
  logic [3:0] mon_q;
  logic       leap_q;
  logic [31:0] t_pend, d_pend;
  logic t_busy, d_busy;
  logic [CW-1:0] t_cnt, d_cnt;

  wire t_commit = t_busy && slow_en && (t_cnt == CW'(COMMIT_SLOW - 1));
  wire d_commit = d_busy && slow_en && (d_cnt == CW'(COMMIT_SLOW - 1));
  wire wr_time  = bus_wr && bus_addr == A_TIME;
  wire wr_date  = bus_wr && bus_addr == A_DATE;

  wire sec_wrap = sec_q >= 6'd59;
  wire min_wrap = min_q >= 6'd59;
  wire hr_wrap  = hr_q  >= 5'd23;
  wire day_carry = sec_tick && !t_commit && sec_wrap && min_wrap && hr_wrap;

  logic [4:0] day_last;
  always_comb begin
    case (mon_q)
      4'd2:                      day_last = leap_q ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   day_last = 5'd30;
      default:                   day_last = 5'd31;
    endcase
  end

  wire [31:0] time_word = {11'd0, hr_q, 2'd0, min_q, 2'd0, sec_q};
  wire [31:0] date_word = {9'd0, leap_q, yr_q, 4'd0, mon_q, 3'd0, day_q};
  wire [31:0] ctrl_word = {23'd0, t_busy, d_busy, 7'd0};

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_word;
      A_TIME:  bus_rdata = time_word;
      A_DATE:  bus_rdata = date_word;
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_busy <= 1'b0; t_cnt <= '0; t_pend <= '0;
    end else if (t_busy) begin
      if (slow_en) begin
        if (t_commit) begin t_busy <= 1'b0; t_cnt <= '0; end
        else t_cnt <= t_cnt + 1'b1;
      end
    end else if (wr_time) begin
      t_busy <= 1'b1; t_cnt <= '0; t_pend <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_busy <= 1'b0; d_cnt <= '0; d_pend <= '0;
    end else if (d_busy) begin
      if (slow_en) begin
        if (d_commit) begin d_busy <= 1'b0; d_cnt <= '0; end
        else d_cnt <= d_cnt + 1'b1;
      end
    end else if (wr_date) begin
      d_busy <= 1'b1; d_cnt <= '0; d_pend <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0;
    end else if (t_commit) begin
      sec_q <= t_pend[5:0]; min_q <= t_pend[13:8]; hr_q <= t_pend[20:16];
    end else if (sec_tick) begin
      sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
      if (sec_wrap) begin
        min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
        if (min_wrap) hr_q <= hr_wrap ? 5'd0 : hr_q + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q <= 5'd1; mon_q <= 4'd1; yr_q <= '0; leap_q <= 1'b0;
    end else if (d_commit) begin
      day_q <= d_pend[4:0]; mon_q <= d_pend[11:8];
      yr_q <= d_pend[21:16]; leap_q <= d_pend[22];
    end else if (day_carry) begin
      if (day_q >= day_last) begin
        day_q <= 5'd1;
        if (mon_q >= 4'd12) begin
          mon_q <= 4'd1;
          yr_q  <= yr_q + 6'd1;
        end else mon_q <= mon_q + 4'd1;
      end else day_q <= day_q + 5'd1;
    end
  end

  // R4
  t_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_busy) |-> $past(wr_time));
  // R4
  d_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_busy) |-> $past(wr_date));
  // R5
  t_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t_busy) |-> $past(slow_en));
  // R6
  t_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_busy && !slow_en) |=> t_busy);
  // R10
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !t_commit) |=> $stable(time_word));
  // R10
  date_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_carry && !d_commit) |=> $stable(date_word));
  // R7
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !t_commit && sec_q < 6'd58) |=> sec_q == $past(sec_q) + 6'd1);
endmodule

// File: tb/sim_clock_calendar.sv
module sim_clock_calendar;
  logic clk = 1'b0, rst_n = 1'b0, slow_en = 1'b0, sec_tick = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  clock_calendar u0 (.clk(clk), .rst_n(rst_n), .slow_en(slow_en), .sec_tick(sec_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  localparam logic [31:0] T_END = 32'h00173B3B;
  // start time, start date, expected time, expected date after one second
  localparam logic [31:0] VEC [0:11][0:3] = '{
    '{32'h00000000, 32'h00000101, 32'h00000001, 32'h00000101},
    '{32'h0000003B, 32'h00000101, 32'h00000100, 32'h00000101},
    '{32'h00003B3B, 32'h00000101, 32'h00010000, 32'h00000101},
    '{T_END,        32'h0005030F, 32'h00000000, 32'h00050310},
    '{T_END,        32'h0005021C, 32'h00000000, 32'h00050301},
    '{T_END,        32'h005E021C, 32'h00000000, 32'h005E021D},
    '{T_END,        32'h005E021D, 32'h00000000, 32'h005E0301},
    '{T_END,        32'h0005041E, 32'h00000000, 32'h00050501},
    '{T_END,        32'h0005011E, 32'h00000000, 32'h0005011F},
    '{T_END,        32'h000A0C1F, 32'h00000000, 32'h000B0101},
    '{T_END,        32'h003F0C1F, 32'h00000000, 32'h00000101},
    '{T_END,        32'h00050B1E, 32'h00000000, 32'h00050C01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic slow_pulse();
    @(negedge clk); slow_en = 1'b1;
    @(negedge clk); slow_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d);
    wr(2'd1, t); slow_pulse(); slow_pulse();
    wr(2'd2, d); slow_pulse(); slow_pulse();
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R1 time", v, 32'h0);
    rd(2'd2, v); chk("R1 date", v, 32'h00000101);
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);

    for (int i = 0; i < 12; i++) begin
      load(VEC[i][0], VEC[i][1]);
      tick();
      rd(2'd1, v);
      rd(2'd2, v2);
      if (i < 3) begin
        chk("R7 time", v, VEC[i][2]); chk("R7 date", v2, VEC[i][3]);
      end else if (i == 9 || i == 10) begin
        chk("R9 time", v, VEC[i][2]); chk("R9 date", v2, VEC[i][3]);
      end else begin
        chk("R8 time", v, VEC[i][2]); chk("R8 date", v2, VEC[i][3]);
      end
    end

    // R4 / R5 busy and commit timing
    load(32'h00010203, 32'h00030405);
    wr(2'd1, 32'h000A0B0C);
    rd(2'd0, v); chk("R4 time busy", v, 32'h00000100);
    rd(2'd1, v); chk("R4 old time kept", v, 32'h00010203);
    slow_pulse();
    rd(2'd0, v); chk("R5 busy after one strobe", v, 32'h00000100);
    rd(2'd1, v); chk("R5 not yet committed", v, 32'h00010203);
    slow_pulse();
    rd(2'd0, v); chk("R5 busy cleared", v, 32'h0);
    rd(2'd1, v); chk("R5 time committed", v, 32'h000A0B0C);
    wr(2'd2, 32'h00070809);
    rd(2'd0, v); chk("R4 date busy", v, 32'h00000080);
    rd(2'd2, v); chk("R4 old date kept", v, 32'h00030405);
    slow_pulse(); slow_pulse();
    rd(2'd2, v); chk("R5 date committed", v, 32'h00070809);

    // R6 writes while busy and control writes
    wr(2'd1, 32'h00020304);
    wr(2'd1, 32'h00111111);
    slow_pulse(); slow_pulse();
    rd(2'd1, v); chk("R6 write while busy ignored", v, 32'h00020304);
    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, v); chk("R6 ctrl write ignored", v, 32'h0);
    rd(2'd1, v); chk("R6 time untouched by ctrl write", v, 32'h00020304);

    // R2 / R3 field masks
    load(32'hFFFFFFFF, 32'hFFFFFFFF);
    rd(2'd1, v); chk("R2 time mask", v, 32'h001F3F3F);
    rd(2'd2, v); chk("R3 date mask", v, 32'h007F0F1F);

    // R10 stability without strobes
    load(32'h00050607, 32'h00040302);
    rd(2'd1, v);
    repeat (5) @(negedge clk);
    slow_pulse();
    rd(2'd1, v2); chk("R10 time stable", v2, v);
    rd(2'd2, v2); chk("R10 date stable", v2, 32'h00040302);

    // R11 commit and tick in the same cycle
    wr(2'd1, T_END);
    slow_pulse();
    @(negedge clk); slow_en = 1'b1; sec_tick = 1'b1;
    @(negedge clk); slow_en = 1'b0; sec_tick = 1'b0;
    rd(2'd1, v); chk("R11 time loaded unadvanced", v, T_END);
    rd(2'd2, v); chk("R11 no day carry", v, 32'h00040302);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule